// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for every beat of a four-beat burst on a synchronous burst memory. Two separate load strobes each capture a start address. One comes from a processor-side master and one from a controller-side master. After a load, each cycle in which the advance input is high moves the burst to its next beat. Only the two lowest address bits change. The upper bits are held exactly as they were captured.

The order selector is sampled together with the start address. It chooses between two orderings of the low bits. Linear order steps the low bits up by one and wraps modulo four. Interleaved order XORs the starting low bits with a beat counter. The block drives the current full address and the index of the current beat, both from registers. A downstream memory pipeline uses these to get a 3-1-1-1 access pattern. The memory array, the write path and the data pipeline are not part of this block.

A small state machine tracks the burst. It has three states. ST_IDLE means no address has been loaded since reset. ST_LOADED means a start address has just been captured and the burst is on its first beat. ST_STEP means the burst has advanced at least once. The transitions are:
- LOAD (any state to ST_LOADED), taken on either strobe.
- FIRST_ADV (ST_LOADED to ST_STEP), taken on advance without a strobe.
- NEXT_ADV (ST_STEP to ST_STEP), taken on advance without a strobe.
- HOLD (stay in the current state), taken when neither input is active.

In ST_IDLE the advance input is ignored.

Top module: `burst_addr_seq`

## Requirements
- R1: During and after reset, before any load, burst_addr is 0 and beat_idx is 0.
- R2: If strobe_a or strobe_b is 1 at a rising edge, then after that edge burst_addr equals the start_addr presented at that edge and beat_idx is 0.
- R3: A strobe in the same cycle as advance wins: the result is a fresh load as in R2, and no advance takes place.
- R4: With order_sel = 0 (linear) latched at load, each advance without a strobe adds 1 modulo 4 to burst_addr[1:0] and adds 1 modulo 4 to beat_idx. A start of 2 gives 2,3,0,1.
- R5: With order_sel = 1 (interleaved) latched at load, burst_addr[1:0] equals the start low bits XOR beat_idx. A start of 1 gives 1,0,3,2, and a start of 3 gives 3,2,1,0.
- R6: A cycle with no strobe and no advance leaves burst_addr and beat_idx unchanged.
- R7: Without a strobe, burst_addr[ADDR_W-1:2] never changes. There is no carry out of the low two bits.
- R8: order_sel is sampled only on a load. Changing it during a burst has no effect on the sequence.
- R9: Advance before the first load after reset has no effect. The outputs stay at 0.
- R10: An advance after the fourth beat wraps back to beat 0 and to the start low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_a | input | 1 | Processor-side load strobe, active high |
| strobe_b | input | 1 | Controller-side load strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| order_sel | input | 1 | Ordering taken at load: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Start address captured on a strobe |
| burst_addr | output | ADDR_W | Current beat address |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Two cases are hard to reach from the ports. The first is a change of the ordering in the middle of a burst. The second is a strobe that collides with an advance after the burst has already stepped away from its start. Neither shows up if each burst is simply loaded and stepped through. The stimulus reaches them with dedicated tasks. One task loads a linear burst and then flips order_sel while advancing, then checks that the linear values continue. Another advances twice and then raises a strobe together with advance, then checks for a fresh beat 0 at the new address. A start address with every upper bit set and low bits of 3 exposes any carry out of the burst field on the wrap.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOADED = 2'd1,
        ST_STEP   = 2'd2
    } bseq_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bseq_order_e;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_any,
    input  logic        adv,
    output bseq_state_e state_o,
    output logic        load_o,
    output logic        step_o
);

    bseq_state_e state_q;
    bseq_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ld_any) state_d = ST_LOADED;
            end
            ST_LOADED: begin
                if (ld_any)   state_d = ST_LOADED;
                else if (adv) state_d = ST_STEP;
            end
            ST_STEP: begin
                if (ld_any)   state_d = ST_LOADED;
                else if (adv) state_d = ST_STEP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o = ld_any;
        step_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   step_o = 1'b0;
            ST_LOADED: step_o = adv && !ld_any;
            ST_STEP:   step_o = adv && !ld_any;
            default:   step_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/burst_lo_gen.sv
module burst_lo_gen
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [BEAT_W-1:0] start_lo,
    input  logic              mode_in,
    output logic [BEAT_W-1:0] lo_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              mode_o
);

    logic [BEAT_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    bseq_order_e       mode_q;
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mode_q <= ORD_LINEAR;
        end else if (load) begin
            base_q <= start_lo;
            beat_q <= '0;
            mode_q <= bseq_order_e'(mode_in);
        end else if (step) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // linear: base plus beat count, wrapping in the field
    assign lin_lo = base_q + beat_q;

    // interleaved: bitwise XOR of base with beat count
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_q[b] ^ beat_q[b];
    end

    always_comb begin
        unique case (mode_q)
            ORD_LINEAR:     lo_o = lin_lo;
            ORD_INTERLEAVE: lo_o = ilv_lo;
            default:        lo_o = lin_lo;
        endcase
    end

    assign beat_o = beat_q;
    assign mode_o = (mode_q == ORD_INTERLEAVE);

endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg #(
    parameter int UP_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [UP_W-1:0] d,
    output logic [UP_W-1:0] q
);

    logic [UP_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [1:0]        beat_idx
);

    localparam int BEAT_W = 2;
    localparam int UP_W   = ADDR_W - BEAT_W;

    bseq_state_e       fsm_state;
    logic              ld_any;
    logic              load_en;
    logic              step_en;
    logic [BEAT_W-1:0] lo_addr;
    logic [BEAT_W-1:0] beat_cnt;
    logic              order_q;
    logic [UP_W-1:0]   upper_q;

    assign ld_any = strobe_a || strobe_b;

    burst_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_any  (ld_any),
        .adv     (advance),
        .state_o (fsm_state),
        .load_o  (load_en),
        .step_o  (step_en)
    );

    burst_lo_gen #(.BEAT_W(BEAT_W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .step     (step_en),
        .start_lo (start_addr[BEAT_W-1:0]),
        .mode_in  (order_sel),
        .lo_o     (lo_addr),
        .beat_o   (beat_cnt),
        .mode_o   (order_q)
    );

    burst_upper_reg #(.UP_W(UP_W)) u_up (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .d     (start_addr[ADDR_W-1:BEAT_W]),
        .q     (upper_q)
    );

    assign burst_addr = {upper_q, lo_addr};
    assign beat_idx   = beat_cnt;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              advance,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] burst_addr,
    input logic [1:0]        beat_idx,
    input logic [1:0]        fsm_state,
    input logic              order_q
);

    logic       ld;
    logic       live;
    logic [1:0] lo;
    logic [1:0] base;

    assign ld   = strobe_a || strobe_b;
    assign live = (fsm_state != 2'd0);
    assign lo   = burst_addr[1:0];
    assign base = lo ^ beat_idx;

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> burst_addr == $past(start_addr)); // R2
    AST_PRIO_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && advance) |=> beat_idx == 2'd0); // R3
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !advance) |=> ($stable(burst_addr) && $stable(beat_idx))); // R6
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])); // R7
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && advance && live && !order_q) |=> lo == 2'($past(lo) + 2'd1)); // R4
    AST_ILV_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && live && order_q) |=> base == $past(base)); // R5
    AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !live) |=> (burst_addr == '0 && beat_idx == 2'd0)); // R9

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_a   (strobe_a),
    .strobe_b   (strobe_b),
    .advance    (advance),
    .start_addr (start_addr),
    .burst_addr (burst_addr),
    .beat_idx   (beat_idx),
    .fsm_state  (fsm_state),
    .order_q    (order_q)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_a = 1'b0;
    logic          strobe_b = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] burst_addr;
    logic [1:0]    beat_idx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_a   (strobe_a),
        .strobe_b   (strobe_b),
        .advance    (advance),
        .order_sel  (order_sel),
        .start_addr (start_addr),
        .burst_addr (burst_addr),
        .beat_idx   (beat_idx)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic sa, input logic sb, input logic adv,
                       input logic mode, input logic [AW-1:0] a);
        strobe_a = sa; strobe_b = sb; advance = adv; order_sel = mode; start_addr = a;
        @(negedge clk);
        strobe_a = 1'b0; strobe_b = 1'b0; advance = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 addr", burst_addr, '0);
        chk("R1 beat", {14'd0, beat_idx}, 16'd0);
    endtask

    task automatic t_adv_idle;
        cyc(0, 0, 1, 0, 16'h1234);
        cyc(0, 0, 1, 1, 16'h1234);
        chk("R9 addr", burst_addr, '0);
        chk("R9 beat", {14'd0, beat_idx}, 16'd0);
    endtask

    task automatic t_linear(input logic [AW-1:0] a);
        cyc(1, 0, 0, 0, a);
        chk("R2 load a", burst_addr, a);
        for (int k = 1; k < 5; k++) begin
            cyc(0, 0, 1, 1'b1, 16'hFFFF);
            chk("R4 lin addr", burst_addr, {a[AW-1:2], 2'(a[1:0] + k)});
            chk("R4 lin beat", {14'd0, beat_idx}, {14'd0, 2'(k)});
        end
        chk("R10 wrap", burst_addr, a);
        chk("R10 beat0", {14'd0, beat_idx}, 16'd0);
    endtask

    task automatic t_ilv(input logic [AW-1:0] a);
        cyc(0, 1, 0, 1, a);
        chk("R2 load b", burst_addr, a);
        for (int k = 1; k < 4; k++) begin
            cyc(0, 0, 1, 1'b0, 16'h0);
            chk("R5 ilv addr", burst_addr, {a[AW-1:2], a[1:0] ^ 2'(k)});
        end
    endtask

    task automatic t_hold;
        cyc(1, 0, 0, 0, 16'h0A01);
        cyc(0, 0, 1, 0, 16'h0);
        for (int k = 0; k < 3; k++) begin
            cyc(0, 0, 0, 1, 16'hFFFF);
            chk("R6 hold addr", burst_addr, 16'h0A02);
            chk("R6 hold beat", {14'd0, beat_idx}, 16'd1);
        end
    endtask

    task automatic t_priority;
        cyc(1, 0, 0, 0, 16'h5550);
        cyc(0, 0, 1, 0, 16'h0);
        cyc(0, 0, 1, 0, 16'h0);
        cyc(0, 1, 1, 1, 16'h3C3E);
        chk("R3 addr", burst_addr, 16'h3C3E);
        chk("R3 beat", {14'd0, beat_idx}, 16'd0);
        cyc(0, 0, 1, 0, 16'h0);
        chk("R3 ilv after", burst_addr, 16'h3C3F);
    endtask

    task automatic t_mode_change;
        cyc(1, 0, 0, 0, 16'h7701);
        cyc(0, 0, 1, 1, 16'h0);
        chk("R8 lin kept 1", burst_addr, 16'h7702);
        cyc(0, 0, 1, 1, 16'h0);
        chk("R8 lin kept 2", burst_addr, 16'h7703);
    endtask

    task automatic t_no_carry;
        cyc(1, 1, 0, 0, 16'hFFFF);
        cyc(0, 0, 1, 0, 16'h0);
        chk("R7 no carry", burst_addr, 16'hFFFC);
        cyc(0, 0, 1, 0, 16'h0);
        chk("R7 upper", burst_addr, 16'hFFFD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_adv_idle();
        t_linear(16'h01F6);
        t_linear(16'hABC3);
        t_ilv(16'h2461);
        t_ilv(16'h2463);
        t_ilv(16'h2462);
        t_hold();
        t_priority();
        t_mode_change();
        t_no_carry();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule